// File: doc/BRIEF.md
# Wide-Operand ALU with Programmable Latency

This block applies one of six arithmetic or logic operations to two wide operands and presents a double-width result. Its controls arrive in the form a register-file front end with 32-bit data would produce. A start or error-clear action is a field value qualified by a one-cycle write strobe. The delay setting and the operation select are each a value plus a write-enable, and the block keeps its own copy of each and drives that copy back out for readback.

A start captures both operands and the current operation. The result is then held back by a software-programmed number of clock cycles before it is latched and flagged done. While the delay runs, the block is busy. Two conditions raise a sticky error flag and cause the start to be ignored: a start that arrives while busy, and a start while the operation select holds an unused code. The error flag stays set until a qualified clear pulse.

Top module: `wide_alu_core`

## Requirements
- R1: After reset, res_o, done_o, busy_o, err_o, dly_o and sel_o are all zero.
- R2: Operation codes are 0 add, 1 subtract, 2 multiply, 3 XOR, 4 AND and 5 OR.
  - Add returns the full sum including the carry into bit OPW.
  - Subtract returns the difference modulo 2^OPW, zero-extended.
  - Multiply returns the full 2*OPW-bit product.
  - The logic operations are zero-extended.
- R3: A start happens only in a cycle where trig_val_i and trig_qe_i are both high. Either one alone changes nothing.
- R4: Take a start sampled at clock edge k with delay setting D. res_o and done_o update at edge k+D, or at edge k itself when D is 0. busy_o is high from edge k until edge k+D, and it never rises when D is 0.
- R5: The operands and the operation are captured at the start edge. Later changes to opa_i or opb_i, and configuration writes, do not alter the running computation.
- R6: An accepted start with D greater than 0 clears done_o. done_o is set when the result is latched, holds until the next accepted start, and is never high together with busy_o.
- R7: A start while busy sets err_o and is ignored. The running computation still completes with its own result.
- R8: A start while sel_o holds 6 or 7 sets err_o and is ignored, leaving res_o, done_o and busy_o unchanged.
- R9: err_o clears only when clr_val_i and clr_qe_i are both high in one cycle. If an error condition occurs in that same cycle, err_o is set instead.
- R10: dly_o loads dly_i only in a cycle with dly_we_i high and otherwise holds its value.
- R11: sel_o loads sel_i only in a cycle with sel_we_i high and otherwise holds its value. A start in the same cycle as a select write uses the old select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_val_i | input | 1 | Start field value |
| trig_qe_i | input | 1 | Write qualifier for the start field |
| clr_val_i | input | 1 | Error-clear field value |
| clr_qe_i | input | 1 | Write qualifier for the error-clear field |
| opa_i | input | OPW | Operand A |
| opb_i | input | OPW | Operand B |
| dly_we_i | input | 1 | Delay setting write-enable |
| dly_i | input | DLY_W | Delay setting write value |
| dly_o | output | DLY_W | Delay setting readback |
| sel_we_i | input | 1 | Operation select write-enable |
| sel_i | input | 3 | Operation select write value |
| sel_o | output | 3 | Operation select readback |
| res_o | output | 2*OPW | Latched result |
| busy_o | output | 1 | Delay in progress |
| done_o | output | 1 | Result latched since the last accepted start |
| err_o | output | 1 | Sticky error flag |

## Verification
The bench targets the carry out of an all-ones add, a subtract that wraps, and the all-ones square. A datapath cut to OPW bits, or one that sign-extends, returns the wrong upper half in these cases.

It also covers delays of 0, 1 and several cycles. An off-by-one counter would latch one edge early or late and miss the scoreboard slot. Likewise, a design that fails to capture its operands would return garbage after the bench scrambles the inputs and rewrites the select in mid-run.

Finally, the bench exercises half-qualified start and clear strobes, a restart while busy, an unused select code, and a clear that collides with a new error. A design that obeys a lone strobe, restarts, or lets the clear win would change the result or the flags where they must hold.

// File: rtl/wide_alu_core.sv
module wide_alu_core #(
  parameter int OPW   = 256,
  parameter int DLY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_val_i,
  input  logic              trig_qe_i,
  input  logic              clr_val_i,
  input  logic              clr_qe_i,
  input  logic [OPW-1:0]    opa_i,
  input  logic [OPW-1:0]    opb_i,
  input  logic              dly_we_i,
  input  logic [DLY_W-1:0]  dly_i,
  output logic [DLY_W-1:0]  dly_o,
  input  logic              sel_we_i,
  input  logic [2:0]        sel_i,
  output logic [2:0]        sel_o,
  output logic [2*OPW-1:0]  res_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int RESW = 2 * OPW;

  logic [DLY_W-1:0] dly_q, cnt_q;
  logic [2:0]       sel_q, op_q;
  logic [OPW-1:0]   a_q, b_q;
  logic [RESW-1:0]  res_q, calc;
  logic             busy_q, done_q, err_q;

  wire go     = trig_val_i & trig_qe_i;
  wire clr    = clr_val_i & clr_qe_i;
  wire bad    = sel_q > 3'd5;
  wire accept = go & ~busy_q & ~bad;
  wire finish = busy_q & (cnt_q == DLY_W'(1));

  wire [OPW-1:0] src_a  = busy_q ? a_q : opa_i;
  wire [OPW-1:0] src_b  = busy_q ? b_q : opb_i;
  wire [2:0]     src_op = busy_q ? op_q : sel_q;
  wire [OPW-1:0] diff   = src_a - src_b;

  always_comb begin
    case (src_op)
      3'd0:    calc = RESW'(src_a) + RESW'(src_b);
      3'd1:    calc = {{OPW{1'b0}}, diff};
      3'd2:    calc = RESW'(src_a) * RESW'(src_b);
      3'd3:    calc = {{OPW{1'b0}}, src_a ^ src_b};
      3'd4:    calc = {{OPW{1'b0}}, src_a & src_b};
      3'd5:    calc = {{OPW{1'b0}}, src_a | src_b};
      default: calc = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
      sel_q <= '0;
    end else begin
      if (dly_we_i) dly_q <= dly_i;
      if (sel_we_i) sel_q <= sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      op_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (accept) begin
      if (dly_q == '0) begin
        res_q  <= calc;
        done_q <= 1'b1;
      end else begin
        a_q    <= opa_i;
        b_q    <= opb_i;
        op_q   <= sel_q;
        cnt_q  <= dly_q;
        busy_q <= 1'b1;
        done_q <= 1'b0;
      end
    end else if (finish) begin
      res_q  <= calc;
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q - DLY_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 err_q <= 1'b0;
    else if (go & (busy_q | bad)) err_q <= 1'b1;
    else if (clr)                err_q <= 1'b0;
  end

  assign dly_o  = dly_q;
  assign sel_o  = sel_q;
  assign res_o  = res_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) !(busy_o && done_o)); // R6
  AST_BUSY_END_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(busy_o) |-> done_o); // R4
  AST_ZERO_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni) (go && !busy_o && !bad && dly_o == '0) |=> (done_o && !busy_o)); // R4
  AST_HALF_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni) (!go && !busy_o) |=> ($stable(res_o) && !$rose(busy_o))); // R3
  AST_BUSY_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni) (go && busy_o) |=> err_o); // R7
  AST_BAD_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni) (go && !busy_o && bad) |=> (err_o && $stable(res_o) && $stable(done_o) && !busy_o)); // R8
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni) (clr && !(go && (busy_o || bad))) |=> !err_o); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) (err_o && !clr) |=> err_o); // R9
  AST_DLY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !dly_we_i |=> $stable(dly_o)); // R10
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !sel_we_i |=> $stable(sel_o)); // R11
endmodule

// File: tb/wide_alu_core_test.sv
module wide_alu_core_test;
  localparam int OPW = 256;
  localparam int DLY_W = 8;
  localparam int RESW = 2 * OPW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_val = 0, trig_qe = 0, clr_val = 0, clr_qe = 0;
  logic [OPW-1:0] opa = '0, opb = '0;
  logic dly_we = 0, sel_we = 0;
  logic [DLY_W-1:0] dly_in = '0, dly_out;
  logic [2:0] sel_in = '0, sel_out;
  logic [RESW-1:0] res;
  logic busy, done, err;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  typedef struct { logic [RESW-1:0] val; int due; string tag; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wide_alu_core #(.OPW(OPW), .DLY_W(DLY_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .trig_val_i(trig_val), .trig_qe_i(trig_qe),
    .clr_val_i(clr_val), .clr_qe_i(clr_qe),
    .opa_i(opa), .opb_i(opb),
    .dly_we_i(dly_we), .dly_i(dly_in), .dly_o(dly_out),
    .sel_we_i(sel_we), .sel_i(sel_in), .sel_o(sel_out),
    .res_o(res), .busy_o(busy), .done_o(done), .err_o(err)
  );

  function automatic logic [RESW-1:0] model(logic [OPW-1:0] a, logic [OPW-1:0] b, logic [2:0] op);
    logic [OPW-1:0] d;
    d = a - b;
    case (op)
      3'd0: return RESW'(a) + RESW'(b);
      3'd1: return RESW'(d);
      3'd2: return RESW'(a) * RESW'(b);
      3'd3: return RESW'(a ^ b);
      3'd4: return RESW'(a & b);
      3'd5: return RESW'(a | b);
      default: return '0;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [RESW-1:0] act, logic [RESW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      check(res == e.val, e.tag, res, e.val);
      check(done && !busy, {e.tag, " done"}, RESW'({done, busy}), RESW'(2'b10));
    end
  end

  task automatic cfg(logic [DLY_W-1:0] d, logic [2:0] op);
    @(negedge clk);
    dly_in = d; sel_in = op; dly_we = 1; sel_we = 1;
    @(negedge clk);
    dly_we = 0; sel_we = 0;
  endtask

  task automatic start(logic [OPW-1:0] a, logic [OPW-1:0] b, logic [2:0] op, int d, string tag);
    exp_t e;
    @(negedge clk);
    opa = a; opb = b; trig_val = 1; trig_qe = 1;
    e.val = model(a, b, op); e.due = cyc + 1 + d; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    trig_val = 0; trig_qe = 0;
  endtask

  task automatic drain();
    int n = 0;
    while (sb.size() > 0 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  localparam logic [OPW-1:0] ONES = '1;
  localparam logic [OPW-1:0] PA = {8{32'hA5C3_0F17}};
  localparam logic [OPW-1:0] PB = {8{32'h3C96_F0E1}};
  logic [RESW-1:0] keep;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(res == '0, "R1 res", res, '0);
    check({done, busy, err} == 3'b000, "R1 flags", RESW'({done, busy, err}), '0);
    check(dly_out == '0 && sel_out == '0, "R1 config", RESW'({dly_out, sel_out}), '0);

    // R2 add keeps carry, delay 0 (R4)
    cfg(0, 0);
    start(ONES, 256'd1, 0, 0, "R2 add carry");
    drain();
    // R2 subtract wraps, delay 3; R5 scramble during run
    cfg(3, 1);
    start(256'd5, 256'd9, 1, 3, "R2 sub wrap / R5 capture");
    check(busy && !done, "R4 busy R6 done cleared", RESW'({busy, done}), RESW'(2'b10));
    opa = PA; opb = PB;
    cfg(7, 4);
    drain();
    // R2 multiply full width, delay 2
    cfg(2, 2);
    start(ONES, ONES, 2, 2, "R2 mul");
    drain();
    cfg(1, 3);
    start(PA, PB, 3, 1, "R2 xor d1");
    drain();
    cfg(5, 4);
    start(PA, PB, 4, 5, "R2 and d5");
    drain();
    cfg(0, 5);
    start(PA, PB, 5, 0, "R2 or d0");
    check(!busy && done, "R4 zero delay no busy", RESW'({busy, done}), RESW'(2'b01));
    drain();
    keep = model(PA, PB, 5);

    // R3 half-qualified start strobes
    @(negedge clk); opa = ONES; opb = ONES; trig_val = 1; trig_qe = 0;
    @(negedge clk); trig_val = 0; trig_qe = 1;
    @(negedge clk); trig_qe = 0;
    repeat (2) @(negedge clk);
    check(res == keep && done && !busy, "R3 no start", res, keep);

    // R7 start while busy
    cfg(4, 0);
    start(PA, PB, 0, 4, "R7 first result kept");
    @(negedge clk);
    opa = ONES; opb = ONES; trig_val = 1; trig_qe = 1;
    @(negedge clk);
    trig_val = 0; trig_qe = 0;
    check(err && busy, "R7 err on busy start", RESW'({err, busy}), RESW'(2'b11));
    drain();
    repeat (3) @(negedge clk);
    check(res == model(PA, PB, 0) && !busy, "R7 no restart", res, model(PA, PB, 0));

    // R9 clear strobes
    @(negedge clk); clr_val = 1; clr_qe = 0;
    @(negedge clk); clr_val = 0; clr_qe = 1;
    @(negedge clk); clr_qe = 0;
    check(err, "R9 half clear ignored", RESW'(err), RESW'(1));
    @(negedge clk); clr_val = 1; clr_qe = 1;
    @(negedge clk); clr_val = 0; clr_qe = 0;
    check(!err, "R9 clear", RESW'(err), RESW'(0));

    // R8 unused select, with R9 collision
    keep = res;
    cfg(0, 6);
    @(negedge clk);
    opa = PA; opb = PB; trig_val = 1; trig_qe = 1; clr_val = 1; clr_qe = 1;
    @(negedge clk);
    trig_val = 0; trig_qe = 0; clr_val = 0; clr_qe = 0;
    check(err, "R9 set wins over clear", RESW'(err), RESW'(1));
    check(res == keep && done && !busy, "R8 bad select ignored", res, keep);

    // R10 / R11 config write-enable and readback
    @(negedge clk); dly_in = 8'd77; sel_in = 3'd5;
    @(negedge clk);
    check(dly_out == 8'd0, "R10 no write without enable", RESW'(dly_out), RESW'(0));
    check(sel_out == 3'd6, "R11 no write without enable", RESW'(sel_out), RESW'(6));
    @(negedge clk); dly_we = 1; sel_we = 1; sel_in = 3'd4;
    @(negedge clk); dly_we = 0; sel_we = 0;
    check(dly_out == 8'd77, "R10 readback", RESW'(dly_out), RESW'(77));
    check(sel_out == 3'd4, "R11 readback", RESW'(sel_out), RESW'(4));

    // R11 start together with select write uses old select
    cfg(0, 4);
    begin
      exp_t e;
      @(negedge clk);
      opa = PA; opb = PB; trig_val = 1; trig_qe = 1; sel_in = 3'd0; sel_we = 1;
      e.val = model(PA, PB, 4); e.due = cyc + 1; e.tag = "R11 old select used";
      sb.push_back(e);
      @(negedge clk);
      trig_val = 0; trig_qe = 0; sel_we = 0;
    end
    drain();
    check(sel_out == 3'd0, "R11 write landed", RESW'(sel_out), RESW'(0));

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule